// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block models the column-access half of a single-bank synchronous DRAM as seen from the device side. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable inputs into read, write or burst-stop commands. For each read or write it walks a burst of column addresses through a small internal page array. Read data comes back on a split data bus after a selectable latency of two or three cycles.

The burst length, the address order and the latency come from mode inputs, which are held static the way a programmed mode register would be. Burst length and order are captured when each command is accepted. A burst in progress can be cut short by any new read, write or legal stop. Read beats that were already fetched keep draining through the latency pipeline while the new command takes over. A byte-lane style mask input blocks individual write beats from being stored and blanks individual read beats on the output.

The engine is meant to sit behind a memory-controller model or a controller under test. It gives cycle-exact column behaviour without row, bank or refresh handling.

Top module: `sdram_burst_engine`

## Requirements
- R1: A command is decoded only while csN is low and rasN is high. casN low with weN high is a read, casN low with weN low is a write, and casN high with weN low is a burst stop. Every other combination, and any combination with csN high, does nothing.
- R2: Beat k of a read accepted at edge T is driven with dqOe high in the cycle after edge T+CL+k. CL is 2 when modeCasLat3 is low and 3 when it is high.
- R3: The burst length and order are captured at the command edge. modeBurstLen codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, code 7 selects full page, and codes 4 to 6 act as 1 beat. After its last beat a burst produces no further output and stores no further data.
- R4: In sequential order (modeInterleave low), beat k of a burst of L beats keeps the start column's upper bits and sets its low log2(L) bits to (start low bits + k) mod L.
- R5: In interleaved order (modeInterleave high, length 2 to 8), beat k keeps the start column's upper bits and sets its low log2(L) bits to the start low bits XOR k.
- R6: A full-page burst visits the columns in ascending order, wraps from the top column to column 0, and ignores modeInterleave. It continues until a read, write or legal stop ends it.
- R7: A write stores dqIn from the command edge as beat 0 and one further beat on each following edge. dqIn presented after the last beat is not stored.
- R8: A write beat whose edge sees dqm high is not stored. dqm high at edge E forces dqOe low in the cycle after edge E+1.
- R9: A read that interrupts a read starts a full-length burst at the new column. Beats of the earlier read fetched up to and including the interrupting edge still appear, ahead of the new read's data.
- R10: A write that interrupts a write restarts the address sequence at the new column for the full programmed length, and the old burst stores nothing more. A write also ends any read burst at its edge.
- R11: A read that interrupts a write takes effect at its own edge, and no remaining write beat is stored.
- R12: A burst stop while modeBurstLen is 7 ends the burst. No write beat is stored on the stop edge, and for a read the beat fetched on the stop edge is the last one delivered.
- R13: A burst stop while modeBurstLen is not 7 raises illegalStop for the one cycle after that edge and otherwise leaves the burst running, including storing the write beat on that edge.
- R14: During reset dqOe and illegalStop are low and dqOut is zero. dqOut is zero in every cycle in which dqOe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| colAddr | input | COL_W | Start column sampled with a read or write |
| dqIn | input | DW | Write data |
| dqm | input | 1 | Data mask for write beats and read output |
| modeBurstLen | input | 3 | Burst length code |
| modeInterleave | input | 1 | 1 selects interleaved order |
| modeCasLat3 | input | 1 | 1 selects latency 3, 0 selects latency 2 |
| dqOut | output | DW | Read data |
| dqOe | output | 1 | Read data valid and driven |
| illegalStop | output | 1 | Pulse for a stop under a non-full-page length |

## Verification
The page is first filled by a full-page write ended by a stop, so every later read can be compared against known contents. Reads are then issued at start columns that sit mid-block and near the block edge, under every length code and both orders. This separates sequential wrap from interleaved XOR and catches a block that fails to wrap at the page top. Interrupt patterns (read over read, write over write, read over write, stops legal and illegal) are each followed by read-back, which shows whether stray beats were stored or dropped. Both latencies are run, with mask pulses placed on chosen beats, to pin down the exact cycle of data and of blanking.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_STOP
  } cmd_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } strobe_t;

  localparam logic [2:0] LEN_CODE_PAGE = 3'd7;
  localparam int MAX_CAS_LAT = 3;

endpackage

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] beatIdx,
  input  logic [COL_W-1:0] blockMask,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;
  logic [COL_W-1:0] stepSum;

  always_comb begin
    stepSum = startCol + beatIdx;
    seqCol  = (startCol & ~blockMask) | (stepSum & blockMask);
    ilvCol  = startCol ^ (beatIdx & blockMask);
    colOut  = interleave ? ilvCol : seqCol;
  end

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [COL_W-1:0] colAddr,
  input  logic [2:0]       modeBurstLen,
  input  logic             modeInterleave,
  output strobe_t          strb,
  output logic [COL_W-1:0] rdAddr,
  output logic [COL_W-1:0] wrAddr,
  output logic             illegalStop
);

  localparam logic [COL_W-1:0] PAGE_MASK = '1;
  localparam logic [COL_W-1:0] ONE_COL   = COL_W'(1);

  function automatic logic [COL_W-1:0] maskOf(input logic [2:0] code);
    case (code)
      3'd1:          maskOf = COL_W'(1);
      3'd2:          maskOf = COL_W'(3);
      3'd3:          maskOf = COL_W'(7);
      LEN_CODE_PAGE: maskOf = PAGE_MASK;
      default:       maskOf = '0;
    endcase
  endfunction

  cmd_e             cmd;
  logic             modeFull;
  logic [COL_W-1:0] newMask;
  logic             legalStop;
  logic             badStop;
  logic             lastBeat;
  logic [COL_W-1:0] curCol;

  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] burstMask;
  logic             burstIlv;
  logic             burstFull;
  logic             rdActive;
  logic             wrActive;

  always_comb begin
    cmd = CMD_NONE;
    if (!csN && rasN) begin
      case ({casN, weN})
        2'b01:   cmd = CMD_READ;
        2'b00:   cmd = CMD_WRITE;
        2'b10:   cmd = CMD_STOP;
        default: cmd = CMD_NONE;
      endcase
    end
  end

  always_comb begin
    modeFull  = (modeBurstLen == LEN_CODE_PAGE);
    newMask   = maskOf(modeBurstLen);
    legalStop = (cmd == CMD_STOP) && modeFull;
    badStop   = (cmd == CMD_STOP) && !modeFull;
    lastBeat  = !burstFull && (beat == burstMask);
  end

  sdram_col_gen #(.COL_W(COL_W)) u_colGen (
    .startCol  (startCol),
    .beatIdx   (beat),
    .blockMask (burstMask),
    .interleave(burstIlv),
    .colOut    (curCol)
  );

  always_comb begin
    strb.rdEn = rdActive;
    strb.wrEn = (cmd == CMD_WRITE) ||
                (wrActive && ((cmd == CMD_NONE) || badStop));
    rdAddr    = curCol;
    wrAddr    = (cmd == CMD_WRITE) ? colAddr : curCol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startCol    <= '0;
      beat        <= '0;
      burstMask   <= '0;
      burstIlv    <= 1'b0;
      burstFull   <= 1'b0;
      rdActive    <= 1'b0;
      wrActive    <= 1'b0;
      illegalStop <= 1'b0;
    end else begin
      illegalStop <= badStop;
      if (cmd == CMD_READ) begin
        startCol  <= colAddr;
        beat      <= '0;
        burstMask <= newMask;
        burstFull <= modeFull;
        burstIlv  <= modeInterleave && !modeFull;
        rdActive  <= 1'b1;
        wrActive  <= 1'b0;
      end else if (cmd == CMD_WRITE) begin
        startCol  <= colAddr;
        beat      <= ONE_COL;
        burstMask <= newMask;
        burstFull <= modeFull;
        burstIlv  <= modeInterleave && !modeFull;
        rdActive  <= 1'b0;
        wrActive  <= (newMask != '0);
      end else if (legalStop) begin
        rdActive  <= 1'b0;
        wrActive  <= 1'b0;
      end else if (rdActive || wrActive) begin
        if (lastBeat) begin
          rdActive <= 1'b0;
          wrActive <= 1'b0;
        end else begin
          beat <= beat + ONE_COL;
        end
      end
    end
  end

  // R11: read and write bursts never run together
  p_one_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdActive, wrActive}));

  // R11: a read command cuts off the write burst at once
  p_read_kills_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) |=> (rdActive && !wrActive));

  // R12: a legal stop leaves no burst running
  p_stop_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    legalStop |=> (!rdActive && !wrActive));

  // R13: an illegal stop is flagged on the next cycle
  p_bad_stop_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    badStop |=> illegalStop);

  // R3: a read burst stops after its last beat
  p_last_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdActive && lastBeat && (cmd == CMD_NONE)) |=> !rdActive);

endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [COL_W-1:0] rdAddr,
  input  logic [COL_W-1:0] wrAddr,
  input  logic [DW-1:0]    dqIn,
  input  logic             dqm,
  input  logic             casLat3,
  output logic [DW-1:0]    dqOut,
  output logic             dqOe
);

  localparam int DEPTH  = 1 << COL_W;
  localparam int STAGES = MAX_CAS_LAT;

  logic [DW-1:0]     pageMem [DEPTH];
  logic [DW-1:0]     stData  [STAGES];
  logic [STAGES-1:0] stValid;
  logic [1:0]        dqmPipe;
  logic              tapValid;
  logic [DW-1:0]     tapData;

  always_ff @(posedge clk) begin
    if (strb.wrEn && !dqm) begin
      pageMem[wrAddr] <= dqIn;
    end
    stData[0] <= pageMem[rdAddr];
    for (int s = 1; s < STAGES; s++) begin
      stData[s] <= stData[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stValid <= '0;
      dqmPipe <= '0;
    end else begin
      stValid <= {stValid[STAGES-2:0], strb.rdEn};
      dqmPipe <= {dqmPipe[0], dqm};
    end
  end

  always_comb begin
    tapValid = casLat3 ? stValid[STAGES-1] : stValid[STAGES-2];
    tapData  = casLat3 ? stData[STAGES-1]  : stData[STAGES-2];
    dqOe     = tapValid && !dqmPipe[1];
    dqOut    = dqOe ? tapData : '0;
  end

  // R8: a mask two edges back blanks the output
  p_mask_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm, 2) |-> !dqOe);

  // R2: with latency 2 an unmasked fetch is driven two edges later
  p_cl2_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!casLat3 && strb.rdEn && !dqm) |=> ##1 (dqOe || casLat3));

  // R14: no data on the bus while output-enable is low
  p_quiet_bus_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !dqOe |-> (dqOut == '0));

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [COL_W-1:0] colAddr,
  input  logic [DW-1:0]    dqIn,
  input  logic             dqm,
  input  logic [2:0]       modeBurstLen,
  input  logic             modeInterleave,
  input  logic             modeCasLat3,
  output logic [DW-1:0]    dqOut,
  output logic             dqOe,
  output logic             illegalStop
);

  strobe_t          strb;
  logic [COL_W-1:0] rdAddr;
  logic [COL_W-1:0] wrAddr;

  sdram_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .csN           (csN),
    .rasN          (rasN),
    .casN          (casN),
    .weN           (weN),
    .colAddr       (colAddr),
    .modeBurstLen  (modeBurstLen),
    .modeInterleave(modeInterleave),
    .strb          (strb),
    .rdAddr        (rdAddr),
    .wrAddr        (wrAddr),
    .illegalStop   (illegalStop)
  );

  sdram_burst_dp #(.COL_W(COL_W), .DW(DW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .dqIn   (dqIn),
    .dqm    (dqm),
    .casLat3(modeCasLat3),
    .dqOut  (dqOut),
    .dqOe   (dqOe)
  );

endmodule

// File: tb/tb_sdram_burst_engine.sv
`timescale 1ns/1ps
module tb_sdram_burst_engine;

  localparam int COL_W = 8;
  localparam int DW    = 16;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [COL_W-1:0] colAddr = '0;
  logic [DW-1:0]    dqIn = '0;
  logic             dqm = 1'b0;
  logic [2:0]       modeBurstLen = 3'd0;
  logic             modeInterleave = 1'b0;
  logic             modeCasLat3 = 1'b0;
  logic [DW-1:0]    dqOut;
  logic             dqOe;
  logic             illegalStop;

  sdram_burst_engine #(.COL_W(COL_W), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .colAddr(colAddr), .dqIn(dqIn), .dqm(dqm), .modeBurstLen(modeBurstLen),
    .modeInterleave(modeInterleave), .modeCasLat3(modeCasLat3),
    .dqOut(dqOut), .dqOe(dqOe), .illegalStop(illegalStop)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string curReq = "R14";
  int    wd = 16'h1000;

  // behavioural reference model
  int mMem [PAGE];
  int rdQ[$];
  int wrQ[$];
  int tmpQ[$];
  int n = 0;
  bit expV [int];
  int expD [int];
  bit expM [int];
  bit expIll [int];

  task automatic buildAddrs(input int start);
    int len;
    int cnt;
    bit full;
    bit ilv;
    int base;
    int off;
    full = (modeBurstLen == 3'd7);
    case (modeBurstLen)
      3'd1: len = 2;
      3'd2: len = 4;
      3'd3: len = 8;
      3'd7: len = PAGE;
      default: len = 1;
    endcase
    cnt  = full ? 4 * PAGE : len;
    ilv  = modeInterleave && !full;
    base = start - (start % len);
    off  = start % len;
    tmpQ.delete();
    for (int k = 0; k < cnt; k++) begin
      if (ilv) tmpQ.push_back(base + (off ^ (k % len)));
      else     tmpQ.push_back(base + ((off + k) % len));
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit isRd, isWr, isStop;
      int a;
      int cl;
      n++;
      isRd   = !csN && rasN && !casN && weN;
      isWr   = !csN && rasN && !casN && !weN;
      isStop = !csN && rasN && casN && !weN;
      cl     = modeCasLat3 ? 3 : 2;
      if (rdQ.size() > 0) begin
        a = rdQ.pop_front();
        expV[n + cl - 1] = 1'b1;
        expD[n + cl - 1] = mMem[a];
      end
      expM[n + 1] = dqm;
      expIll[n]   = isStop && (modeBurstLen != 3'd7);
      if (isRd) begin
        buildAddrs(int'(colAddr));
        rdQ = tmpQ;
        wrQ.delete();
      end else if (isWr) begin
        buildAddrs(int'(colAddr));
        wrQ = tmpQ;
        a = wrQ.pop_front();
        if (!dqm) mMem[a] = int'(dqIn);
        rdQ.delete();
      end else if (isStop && modeBurstLen == 3'd7) begin
        rdQ.delete();
        wrQ.delete();
      end else if (wrQ.size() > 0) begin
        a = wrQ.pop_front();
        if (!dqm) mMem[a] = int'(dqIn);
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && n > 0 && !done) begin
      bit eo;
      int ed;
      eo = expV.exists(n) && expV[n] && !(expM.exists(n) && expM[n]);
      ed = eo ? expD[n] : 0;
      chk("dqOe", int'(dqOe), int'(eo));
      chk("dqOut", int'(dqOut), ed);
      chk("illegalStop", int'(illegalStop), int'(expIll.exists(n) && expIll[n]));
    end
  end

  task automatic put(input bit c, input bit r, input bit ca, input bit w,
                     input int col, input int d, input bit m);
    @(negedge clk);
    csN = c; rasN = r; casN = ca; weN = w;
    colAddr = COL_W'(col); dqIn = DW'(d); dqm = m;
  endtask

  task automatic nopc(input int k);
    for (int i = 0; i < k; i++) put(0, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic rdCmd(input int col);
    put(0, 1, 0, 1, col, 0, 0);
  endtask

  task automatic wrCmd(input int col);
    wd++;
    put(0, 1, 0, 0, col, wd, 0);
  endtask

  task automatic beat(input bit m);
    wd++;
    put(0, 1, 1, 1, 0, wd, m);
  endtask

  task automatic stopCmd();
    wd++;
    put(0, 1, 1, 0, 0, wd, 0);
  endtask

  task automatic setMode(input int len, input bit ilv, input bit cl3);
    nopc(6);
    modeBurstLen = 3'(len); modeInterleave = ilv; modeCasLat3 = cl3;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      curReq = "R14";
      chk("reset dqOe", int'(dqOe), 0);
      chk("reset dqOut", int'(dqOut), 0);
      chk("reset illegalStop", int'(illegalStop), 0);
    end
    csN = 1'b0;
    rst_n = 1'b1;

    // R7 R6 R12: fill the page with a full-page write ended by a stop
    curReq = "R7";
    setMode(7, 0, 0);
    wrCmd(0);
    for (int i = 1; i < PAGE; i++) beat(0);
    curReq = "R12";
    stopCmd();
    nopc(3);

    // R6: full-page read wraps across the page top
    curReq = "R6";
    rdCmd(250);
    nopc(11);
    stopCmd();

    // R4 R2: sequential 4-beat reads, latency 2
    curReq = "R4";
    setMode(2, 0, 0);
    rdCmd(5);
    nopc(8);
    rdCmd(8'h0e);
    nopc(8);

    // R5: interleaved 8-beat reads
    curReq = "R5";
    setMode(3, 1, 0);
    rdCmd(8'h13);
    nopc(10);
    rdCmd(8'h1e);
    nopc(10);

    // R3: lengths 2, 1 and a reserved code
    curReq = "R3";
    setMode(1, 0, 0);
    rdCmd(8'h31);
    nopc(6);
    setMode(0, 0, 0);
    rdCmd(8'h32);
    nopc(6);
    setMode(5, 1, 0);
    rdCmd(8'h33);
    nopc(6);

    // R1: deselected write pattern and a row-strobe-low pattern do nothing
    curReq = "R1";
    setMode(2, 0, 0);
    put(1, 1, 0, 0, 8'h40, 16'hdead, 0);
    put(1, 1, 0, 1, 8'h44, 0, 0);
    put(0, 0, 0, 0, 8'h40, 16'hbeef, 0);
    put(0, 0, 0, 1, 8'h44, 0, 0);
    nopc(4);
    rdCmd(8'h40);
    nopc(8);

    // R7 R8: write with a masked beat, trailing data ignored
    curReq = "R8";
    wrCmd(8'h22);
    beat(0);
    beat(1);
    beat(0);
    beat(0);
    beat(0);
    nopc(2);
    rdCmd(8'h20);
    nopc(8);

    // R8: read output masking
    rdCmd(8'h24);
    put(0, 1, 1, 1, 0, 0, 1);
    nopc(1);
    put(0, 1, 1, 1, 0, 0, 1);
    nopc(8);

    // R9: read interrupted by read
    curReq = "R9";
    setMode(3, 0, 0);
    rdCmd(8'h40);
    nopc(3);
    rdCmd(8'h55);
    nopc(12);

    // R10: write interrupted by write, then read back both blocks
    curReq = "R10";
    wrCmd(8'h60);
    beat(0);
    beat(0);
    wrCmd(8'h6b);
    for (int i = 0; i < 9; i++) beat(0);
    rdCmd(8'h60);
    nopc(9);
    rdCmd(8'h68);
    nopc(10);
    // R10: write ends a read burst
    rdCmd(8'h70);
    nopc(1);
    wrCmd(8'h78);
    for (int i = 0; i < 8; i++) beat(0);
    nopc(4);

    // R11: read interrupts a write
    curReq = "R11";
    wrCmd(8'h80);
    beat(0);
    beat(0);
    rdCmd(8'h80);
    nopc(12);

    // R12: legal stops on full-page read and write
    curReq = "R12";
    setMode(7, 0, 0);
    rdCmd(8'h88);
    nopc(6);
    stopCmd();
    nopc(5);
    wrCmd(8'h90);
    for (int i = 0; i < 4; i++) beat(0);
    stopCmd();
    beat(0);
    beat(0);
    setMode(3, 0, 0);
    rdCmd(8'h90);
    nopc(10);

    // R13: stops under a fixed length are flagged and ignored
    curReq = "R13";
    setMode(2, 0, 0);
    rdCmd(8'ha0);
    stopCmd();
    nopc(6);
    wrCmd(8'ha4);
    beat(0);
    stopCmd();
    beat(0);
    beat(0);
    rdCmd(8'ha4);
    nopc(8);

    // R2: latency 3 with an interrupt and a mask
    curReq = "R2";
    setMode(2, 1, 1);
    rdCmd(8'h13);
    nopc(2);
    rdCmd(8'h55);
    put(0, 1, 1, 1, 0, 0, 1);
    nopc(10);
    setMode(3, 0, 1);
    rdCmd(8'hfd);
    nopc(12);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule